// File: doc/BRIEF.md
# Sub-word Memory Lane Unit

This block is a small data memory built from 64-bit rows. It serves loads and stores of 1, 2, 4 or 8 bytes. A byte address is split into a row index and a byte offset inside the row. The addressed lane is pulled out of the row, or put into it, by shifting and masking.

A store is a read-modify-write of one row, so bytes outside the addressed lane keep their values. Each request can ask for the data to be byte-reversed over exactly its own width. A request whose offset is not a multiple of its width is refused and flagged. Every row is cleared by reset, so a row that has never been written reads as zero.

A request is offered for one cycle with `req_valid`. The response appears on the registered outputs one cycle later.

Top module: `lane_mem`

## Requirements
- R1: The row index is `req_addr >> 3` and the byte offset is `req_addr[2:0]`. Stores to one row leave every other row unchanged.
- R2: `req_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A request whose offset is not a multiple of its width is misaligned. The cycle after a misaligned request, `rsp_err` is 1 for one cycle and `rsp_rdata` is zero, and no row changes.
- R3: An aligned load returns the addressed lane zero-extended at bit 0 on `rsp_rdata` one cycle after the request. The lowest-addressed byte of the lane ends up in bits 7:0.
- R4: A narrow store (1, 2 or 4 bytes) changes only the addressed bytes of its row.
- R5: An 8-byte store replaces the whole row. Bits of `req_wdata` above the access width are ignored.
- R6: A load with `req_swap` set returns its lane byte-reversed over the access width.
- R7: A store with `req_swap` set byte-reverses the low access-width bytes of `req_wdata` before writing them.
- R8: A row that has not been written since reset reads as zero.
- R9: A load in the cycle right after a store to the same row returns the stored data.
- R10: `rsp_valid` follows `req_valid` by one cycle. Store responses carry zero on `rsp_rdata`.
- R11: While reset is active and just after it, `rsp_valid`, `rsp_err` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears outputs and all rows |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Byte-reverse over the access width |
| req_size | input | 2 | Width code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_addr | input | AW (7 by default) | Byte address |
| req_wdata | input | 64 | Store data, lane value at bit 0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was misaligned |
| rsp_rdata | output | 64 | Load result, zero-extended |

## Verification
A wrong mask or shift in the store path stays hidden until the same row is read back. It then shows as altered neighbour bytes, or as a lane at the wrong offset, on the first load of that row. For this reason, random stores are always followed by full-row and narrow loads that are checked against a byte-level model.

A fault in the alignment check shows one cycle after the request, as a wrong `rsp_err`. A fault that lets a refused store write memory only shows on a later load of the row it touched. The swap paths are checked in both directions, so that a reversal over the wrong width shows as misplaced bytes.

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int ROWS = 16,
  localparam int AW = $clog2(ROWS) + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_swap,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [63:0]   rsp_rdata
);
  localparam int OFFW = 3;
  localparam int IW   = AW - OFFW;

  logic [63:0] rows_q [ROWS];

  function automatic logic [63:0] rev_bytes(input logic [63:0] d, input logic [1:0] sz);
    int n;
    logic [63:0] o;
    n = 1 << sz;
    o = '0;
    for (int i = 0; i < 8; i++)
      if (i < n) o[8*i +: 8] = d[8*(n-1-i) +: 8];
    return o;
  endfunction

  logic [IW-1:0]   row_idx;
  logic [OFFW-1:0] offs;
  logic [OFFW-1:0] low_mask;
  logic [5:0]      shamt;
  logic [63:0]     lane_mask;
  logic            misaligned;
  logic [63:0]     cur_row;
  logic [63:0]     ld_lane;
  logic [63:0]     st_data;
  logic [63:0]     new_row;

  assign row_idx    = req_addr[AW-1:OFFW];
  assign offs       = req_addr[OFFW-1:0];
  assign low_mask   = {req_size == 2'd3, req_size >= 2'd2, req_size >= 2'd1};
  assign misaligned = |(offs & low_mask);
  assign shamt      = {offs, 3'b000};
  assign lane_mask  = (req_size == 2'd3) ? {64{1'b1}}
                                         : ((64'd1 << (6'd8 << req_size)) - 64'd1);
  assign cur_row    = rows_q[row_idx];
  assign ld_lane    = req_swap ? rev_bytes((cur_row >> shamt) & lane_mask, req_size)
                               : ((cur_row >> shamt) & lane_mask);
  assign st_data    = (req_swap ? rev_bytes(req_wdata, req_size) : req_wdata) & lane_mask;
  assign new_row    = (cur_row & ~(lane_mask << shamt)) | (st_data << shamt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
    end else if (req_valid && req_write && !misaligned) begin
      rows_q[row_idx] <= new_row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && misaligned;
      rsp_rdata <= (req_valid && !req_write && !misaligned) ? ld_lane : '0;
    end
  end

  // R2
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 64'd0);
  // R2
  half_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd1 && req_addr[0]) |=> rsp_err);
  // R2
  err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid));
  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  store_zero_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == 64'd0);
  // R3
  byte_load_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0) |=> rsp_rdata[63:8] == 56'd0);
  // R11
  idle_after_reset_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (!rsp_valid && !rsp_err && rsp_rdata == 64'd0));
endmodule

// File: tb/lane_mem_bench.sv
module lane_mem_bench;
  localparam int ROWS = 16;
  localparam int AW = $clog2(ROWS) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_swap = 1'b0;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] model [ROWS];

  always #5 clk = ~clk;

  lane_mem #(.ROWS(ROWS)) u_lane_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_swap(req_swap), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata));

  function automatic logic [7:0] get_byte(input logic [63:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input string tag, input bit wr, input bit sw, input logic [1:0] sz,
                      input logic [AW-1:0] a, input logic [63:0] wd);
    int nb, off, r;
    bit bad;
    logic [63:0] exp_rd;
    logic [63:0] row;
    nb  = 1 << sz;
    off = int'(a) % 8;
    r   = int'(a) / 8;
    bad = (off % nb) != 0;
    exp_rd = '0;
    row = model[r];
    if (!bad) begin
      if (wr) begin
        for (int k = 0; k < nb; k++)
          row[8*(off+k) +: 8] = sw ? get_byte(wd, nb-1-k) : get_byte(wd, k);
        model[r] = row;
      end else begin
        for (int k = 0; k < nb; k++)
          exp_rd[8*k +: 8] = sw ? get_byte(row, off+nb-1-k) : get_byte(row, off+k);
      end
    end
    req_valid = 1'b1; req_write = wr; req_swap = sw; req_size = sz;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    check({tag, " err"}, {63'd0, rsp_err}, {63'd0, bad});
    check({tag, " data"}, rsp_rdata, exp_rd);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int seed_dummy;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", {63'd0, rsp_valid}, 64'd0);
    check("R11 err", {63'd0, rsp_err}, 64'd0);
    check("R11 data", rsp_rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle", rsp_rdata, 64'd0);
    // R8 never written
    xact("R8", 0, 0, 2'd3, 7'd40, '0);
    // R5 full store, R3 load back
    xact("R5", 1, 0, 2'd3, 7'd0, 64'h1122334455667788);
    xact("R3", 0, 0, 2'd3, 7'd0, '0);
    // R4 narrow byte store, R9 back-to-back load
    xact("R4", 1, 0, 2'd0, 7'd2, 64'h0000_00AB);
    xact("R9", 0, 0, 2'd3, 7'd0, '0);
    check("R4 literal", model[0], 64'h11223344_55AB7788);
    // R6 swapped load
    xact("R6", 0, 1, 2'd2, 7'd4, '0);
    // R7 swapped store then plain load
    xact("R7", 1, 1, 2'd1, 7'd8, 64'h1234);
    xact("R7", 0, 0, 2'd1, 7'd8, '0);
    // R2 misaligned store refused
    xact("R2", 1, 0, 2'd2, 7'd2, 64'hDEADBEEF);
    xact("R2", 0, 0, 2'd3, 7'd0, '0);
    xact("R2", 0, 0, 2'd3, 7'd7, '0);
    // R5 upper bits ignored
    xact("R5", 1, 0, 2'd0, 7'd16, 64'hFFFF_FFFF_FFFF_FF5A);
    xact("R5", 0, 0, 2'd3, 7'd16, '0);
    // R1 other rows untouched
    xact("R1", 0, 0, 2'd3, 7'd24, '0);
    xact("R1", 0, 0, 2'd2, 7'd4, '0);
    // R10 random mix
    seed_dummy = $urandom(32'h1357_2468);
    for (int t = 0; t < 3000; t++) begin
      logic [1:0] sz;
      logic [AW-1:0] a;
      logic [63:0] wd;
      sz = 2'($urandom_range(0, 3));
      a  = AW'($urandom);
      if ($urandom_range(0, 9) < 8) a = a & ~AW'((1 << sz) - 1);
      wd = {$urandom, $urandom};
      xact("R10", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, sz, a, wd);
      if ((t % 97) == 0) @(negedge clk);
    end
    // final sweep of every row (R1)
    for (int r = 0; r < ROWS; r++) xact("R1", 0, 0, 2'd3, AW'(r * 8), '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule